// File: doc/BRIEF.md
# Wide Immediate Move Unit

This datapath block forms a register-width result from a 16-bit immediate placed at a selectable 16-bit slot. It can also form an address relative to the program counter. Five operations are selected by a 3-bit mode code:

- **Zero-fill** places the immediate and clears every other bit.
- **Inverted** returns the complement of the zero-fill pattern.
- **Insert** overwrites one 16-bit slot of an old destination value and keeps every other bit.
- **Near address** adds a signed 21-bit byte offset to the PC.
- **Page address** scales the same offset by 4 KiB and adds it to the PC rounded down to its 4 KiB boundary.

A width select chooses between full 64-bit operation and 32-bit operation for the three immediate modes. In 32-bit operation the upper half of the result is forced to zero.

A two-state sequencer registers each accepted operation. It has two states:

- **ST_IDLE**: no result is presented.
- **ST_ISSUE**: the registered result is presented with `out_valid` high.

It has two transitions, each taken at a clock edge:

- **ACCEPT**: taken to ST_ISSUE whenever `in_valid` is high, from either state.
- **DRAIN**: taken to ST_IDLE whenever `in_valid` is low, from either state.

Top module: `wim_unit`

## Requirements
- R1: Mode code 0 (zero-fill) yields the immediate shifted left by 16 × `in_sel`, with all other bits 0.
- R2: Mode code 1 (inverted) yields the bitwise complement of the R1 pattern.
- R3: Mode code 2 (insert) yields `in_old` with bits [16·sel+15 : 16·sel] replaced by the immediate; all other bits of `in_old` pass through.
- R4: With `in_wide` = 0 (32-bit operation), modes 0 to 2 yield a result whose bits 63..32 are 0, including after inversion.
- R5: With `in_wide` = 0, an `in_sel` of 2 or 3 in modes 0 to 2 sets `out_illegal` to 1 and forces `out_result` to 0. All other legal operations give `out_illegal` = 0.
- R6: Mode code 3 (near address) yields `in_pc` plus the sign-extended 21-bit `in_ofs`. `in_wide` and `in_sel` have no effect on it.
- R7: Mode code 4 (page address) yields `in_pc` with bits 11..0 cleared, plus the sign-extended `in_ofs` shifted left by 12. `in_wide` and `in_sel` have no effect on it.
- R8: Timing and hold:
  - `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
  - Results appear one clock edge after the input.
  - A cycle with `in_valid` low leaves `out_result` and `out_illegal` unchanged.
- R9: Mode codes 5, 6 and 7 are unsupported: they set `out_illegal` to 1 and yield `out_result` = 0.
- R10: While reset is active and after it is released, before any input, `out_valid`, `out_illegal` and `out_result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_mode | input | 3 | Mode code: 0 zero-fill, 1 inverted, 2 insert, 3 near address, 4 page address |
| in_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| in_imm | input | 16 | Immediate value |
| in_sel | input | 2 | Slot selector; the shift is 16 × in_sel |
| in_old | input | 64 | Old destination value used by insert mode |
| in_pc | input | 64 | Program counter |
| in_ofs | input | 21 | Signed offset for the address modes |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Registered result |
| out_illegal | output | 1 | Registered illegal-operation flag |

## Verification
The bench builds the unit with its default parameters:

| Parameter | Value |
|---|---|
| Data width | 64 |
| Immediate width | 16 |
| Offset width | 21 |
| Page granule | 12 bits |

With these values the full cross of all eight mode codes, both widths and all four slot selectors can be swept against six operand patterns each. The patterns put the immediate at 0, all ones and a split-sign value. The offset takes its most positive, most negative and −1 values. The PC sits just below a page boundary and at the top of the address space, so wrap-around in both address modes is exercised. Operations are issued back to back, so the ACCEPT self-loop is covered. A quiet stretch with changing inputs covers DRAIN and the hold behaviour.

// File: rtl/wim_pkg.sv
package wim_pkg;

    typedef enum logic [2:0] {
        MD_ZERO = 3'd0,
        MD_INV  = 3'd1,
        MD_KEEP = 3'd2,
        MD_NEAR = 3'd3,
        MD_PAGE = 3'd4
    } wim_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } wim_state_e;

endpackage

// File: rtl/wim_shaper.sv
module wim_shaper
    import wim_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16,
    parameter int SEL_W = 2
) (
    input  logic [2:0]       mode_i,
    input  logic             wide_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [XLEN-1:0]  old_i,
    output logic [XLEN-1:0]  val_o,
    output logic             bad_sel_o
);
    localparam int HALF       = XLEN / 2;
    localparam int HALF_SLOTS = HALF / IMM_W;
    localparam int POS_W      = $clog2(XLEN);
    localparam logic [XLEN-1:0] LOW_MASK  = {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
    localparam logic [XLEN-1:0] SLOT_ONES = {{(XLEN-IMM_W){1'b0}}, {IMM_W{1'b1}}};

    logic [POS_W-1:0] pos;
    logic [XLEN-1:0]  placed;
    logic [XLEN-1:0]  fmask;
    logic [XLEN-1:0]  raw;

    assign pos       = POS_W'(sel_i) * POS_W'(IMM_W);
    assign placed    = XLEN'(imm_i) << pos;
    assign fmask     = SLOT_ONES << pos;
    assign bad_sel_o = !wide_i && ({1'b0, sel_i} >= (SEL_W+1)'(HALF_SLOTS));

    always_comb begin
        unique case (mode_i)
            MD_ZERO: raw = placed;
            MD_INV:  raw = ~placed;
            MD_KEEP: raw = (old_i & ~fmask) | placed;
            default: raw = '0;
        endcase
    end

    assign val_o = wide_i ? raw : (raw & LOW_MASK);

endmodule

// File: rtl/wim_addr_gen.sv
module wim_addr_gen #(
    parameter int XLEN    = 64,
    parameter int OFS_W   = 21,
    parameter int PAGE_SH = 12
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             page_i,
    output logic [XLEN-1:0]  addr_o
);
    logic [XLEN-1:0] sofs;
    logic [XLEN-1:0] page_base;
    logic [XLEN-1:0] near_addr;
    logic [XLEN-1:0] page_addr;

    assign sofs      = {{(XLEN-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
    assign page_base = {pc_i[XLEN-1:PAGE_SH], {PAGE_SH{1'b0}}};
    assign near_addr = pc_i + sofs;
    assign page_addr = page_base + (sofs << PAGE_SH);
    assign addr_o    = page_i ? page_addr : near_addr;

endmodule

// File: rtl/wim_seq.sv
module wim_seq
    import wim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    output logic load_o,
    output logic vld_o
);
    wim_state_e state_q;
    wim_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = take_i ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = take_i ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o = take_i;
        vld_o  = (state_q == ST_ISSUE);
    end

    // R8
    accept_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> state_q == ST_ISSUE);

    // R8
    drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> state_q == ST_IDLE);

endmodule

// File: rtl/wim_unit.sv
module wim_unit
    import wim_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int IMM_W   = 16,
    parameter int SEL_W   = 2,
    parameter int OFS_W   = 21,
    parameter int PAGE_SH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_mode,
    input  logic             in_wide,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [SEL_W-1:0] in_sel,
    input  logic [XLEN-1:0]  in_old,
    input  logic [XLEN-1:0]  in_pc,
    input  logic [OFS_W-1:0] in_ofs,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic             out_illegal
);
    localparam int HALF       = XLEN / 2;
    localparam int HALF_SLOTS = HALF / IMM_W;

    logic [XLEN-1:0] shaped;
    logic [XLEN-1:0] addr;
    logic            bad_sel;
    logic            is_move;
    logic            is_addr;
    logic            ill_d;
    logic [XLEN-1:0] res_d;
    logic            load;
    logic [XLEN-1:0] res_q;
    logic            ill_q;

    wim_shaper #(.XLEN(XLEN), .IMM_W(IMM_W), .SEL_W(SEL_W)) u_shaper (
        .mode_i   (in_mode),
        .wide_i   (in_wide),
        .imm_i    (in_imm),
        .sel_i    (in_sel),
        .old_i    (in_old),
        .val_o    (shaped),
        .bad_sel_o(bad_sel)
    );

    wim_addr_gen #(.XLEN(XLEN), .OFS_W(OFS_W), .PAGE_SH(PAGE_SH)) u_addr (
        .pc_i  (in_pc),
        .ofs_i (in_ofs),
        .page_i(in_mode == MD_PAGE),
        .addr_o(addr)
    );

    wim_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .take_i(in_valid),
        .load_o(load),
        .vld_o (out_valid)
    );

    always_comb begin
        is_move = (in_mode == MD_ZERO) || (in_mode == MD_INV) || (in_mode == MD_KEEP);
        is_addr = (in_mode == MD_NEAR) || (in_mode == MD_PAGE);
        ill_d   = !(is_move || is_addr) || (is_move && bad_sel);
        if (ill_d)        res_d = '0;
        else if (is_addr) res_d = addr;
        else              res_d = shaped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            ill_q <= 1'b0;
        end else if (load) begin
            res_q <= res_d;
            ill_q <= ill_d;
        end
    end

    assign out_result  = res_q;
    assign out_illegal = ill_q;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result) && $stable(out_illegal));

    // R5
    narrow_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_wide && ({1'b0, in_sel} >= (SEL_W+1)'(HALF_SLOTS)) && (in_mode <= 3'd2)
        |=> out_illegal && (out_result == '0));

    // R4
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_wide && (in_mode <= 3'd2) |=> out_result[XLEN-1:HALF] == '0);

    // R1
    zero_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_mode == 3'd0) |=> $countones(out_result) <= IMM_W);

    // R2
    inv_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_wide && (in_mode == 3'd1) |=> $countones(out_result) >= (XLEN - IMM_W));

    // R9
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_mode >= 3'd5) |=> out_illegal && (out_result == '0));

endmodule

// File: tb/sim_wim_unit.sv
module sim_wim_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_mode;
    logic        in_wide;
    logic [15:0] in_imm;
    logic [1:0]  in_sel;
    logic [63:0] in_old;
    logic [63:0] in_pc;
    logic [20:0] in_ofs;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

    always #10 clk = ~clk;

    wim_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_wide(in_wide), .in_imm(in_imm), .in_sel(in_sel), .in_old(in_old),
        .in_pc(in_pc), .in_ofs(in_ofs), .out_valid(out_valid),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg;
    endfunction

    function automatic string tag_of(input int m, input bit w, input int s);
        if (m >= 5) return "R9";
        if (m <= 2 && !w && s >= 2) return "R5";
        if (m <= 2 && !w) return "R4";
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model(input int m, input bit w, input logic [15:0] imm, input int s,
                         input logic [63:0] old, input logic [63:0] pc, input logic [20:0] ofs,
                         output logic [63:0] r, output bit ill);
        logic [63:0] p2;
        logic [63:0] field;
        longint      so;
        p2  = 64'd1 << (16 * s);
        so  = (ofs >= 21'd1048576) ? longint'(ofs) - 2097152 : longint'(ofs);
        ill = 1'b0;
        case (m)
            0: r = 64'(imm) * p2;
            1: r = 64'hFFFF_FFFF_FFFF_FFFF - 64'(imm) * p2;
            2: begin
                field = (old / p2) % 64'd65536;
                r = old - field * p2 + 64'(imm) * p2;
            end
            3: r = pc + 64'(so);
            4: r = (pc - pc % 64'd4096) + 64'(so) * 64'd4096;
            default: begin r = 64'd0; ill = 1'b1; end
        endcase
        if (m <= 2 && !w) begin
            r = r % 64'h1_0000_0000;
            if (s >= 2) ill = 1'b1;
        end
        if (ill) r = 64'd0;
    endtask

    task automatic issue(input int m, input bit w, input int s, input int k);
        logic [63:0] er;
        bit          ei;
        string       tg;
        in_valid = 1'b1;
        in_mode  = 3'(m);
        in_wide  = w;
        in_sel   = 2'(s);
        case (k)
            0: begin in_imm = 16'h0000; in_old = 64'hFFFF_FFFF_FFFF_FFFF; in_pc = 64'h0000_0000_1234_5FFF; in_ofs = 21'h0FFFFF; end
            1: begin in_imm = 16'hFFFF; in_old = 64'h0;                   in_pc = 64'hFFFF_FFFF_FFFF_F000; in_ofs = 21'h100000; end
            2: begin in_imm = 16'h8001; in_old = 64'hA5A5_5A5A_C3C3_3C3C; in_pc = 64'h0000_0000_0000_0000; in_ofs = 21'h1FFFFF; end
            3: begin in_imm = 16'h7FFE; in_old = next_rand();             in_pc = 64'hFFFF_FFFF_FFFF_FFFC; in_ofs = 21'h000004; end
            default: begin in_imm = 16'(next_rand()); in_old = next_rand(); in_pc = next_rand(); in_ofs = 21'(next_rand()); end
        endcase
        model(m, w, in_imm, s, in_old, in_pc, in_ofs, er, ei);
        tg = tag_of(m, w, s);
        @(negedge clk);
        check(tg, "result", out_result, er);
        check(ei ? tg : "R5", "illegal", {63'd0, out_illegal}, {63'd0, ei});
        check("R8", "valid", {63'd0, out_valid}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        bit          held_ill;
        rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_wide = 1'b1; in_imm = '0;
        in_sel = '0; in_old = '0; in_pc = '0; in_ofs = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "valid", {63'd0, out_valid}, 64'd0);
        check("R10", "result", out_result, 64'd0);
        check("R10", "illegal", {63'd0, out_illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "valid after release", {63'd0, out_valid}, 64'd0);
        check("R10", "result after release", out_result, 64'd0);

        // sweep: back-to-back issue covers R1-related modes through R9
        for (int m = 0; m < 8; m++)
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 4; s++)
                    for (int k = 0; k < 6; k++)
                        issue(m, w[0], s, k);

        // R8: quiet cycles with changing inputs hold the last result
        issue(1, 1'b1, 2, 2);
        held     = out_result;
        held_ill = out_illegal;
        for (int q = 0; q < 4; q++) begin
            in_valid = 1'b0;
            in_mode  = 3'(q);
            in_imm   = 16'(next_rand());
            in_old   = next_rand();
            in_pc    = next_rand();
            in_ofs   = 21'(next_rand());
            @(negedge clk);
            check("R8", "valid low", {63'd0, out_valid}, 64'd0);
            check("R8", "result held", out_result, held);
            check("R8", "illegal held", {63'd0, out_illegal}, {63'd0, held_ill});
        end
        // R8: next accepted op appears after one edge
        issue(0, 1'b1, 3, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule